// File: doc/BRIEF.md
# Serial Conversion Result Readout Port

This block is the digital back end of a two-channel serial converter readout. A host starts a conversion by pulling an active-low start line low and keeps it low for the whole cycle. The block answers on a single serial data line with a separate output-enable, which a pad cell turns into a three-state pin. When the start line falls, the line is driven low to show that a conversion is in progress. After a latency set by configuration, the line goes high. This rising level is the ready marker. The block then shifts out the result word on falling edges of a clock that the host supplies.

The converter is modelled by two parallel result inputs, one for each channel. A channel-select input picks which result is read. The block latches that choice at the start of the cycle and latches the chosen result when ready is raised. The start line and the serial clock come from another clock domain. Each passes through a two-flop synchronizer before its edges are detected on the system clock. If the host releases the start line before all sixteen clock pulses have arrived, the cycle is aborted. The line is then released a fixed number of system clocks later than it would be at the end of a complete read.

Top module: `serial_readout_port`

## Requirements
- R1: While `rst_n` is low, `sdat_oe` is low at once, with no clock edge needed. In idle, `sdat_oe` stays low.
- R2: A falling edge on `conv_n` makes `sdat_oe` go high at the third rising `clk` edge, counting as edge one the first edge at which the new level is present. `sdat_o` is low from that edge on.
- R3: `lat_cfg` is captured when the cycle starts. `sdat_o` goes high exactly `lat_cfg`+1 clock cycles after `sdat_oe` goes high. This rising edge is the ready marker.
- R4: While the word is being read, each falling edge of `sclk` advances `sdat_o` by one bit, most significant bit first. The change appears at the third rising `clk` edge after the falling edge, counted as in R2.
- R5: A host that samples `sdat_o` on the 16 rising edges of `sclk` captures a 16-bit word. Its bit 15 is 1 and its bits 14 down to 0 are the selected 15-bit result.
- R6: If `conv_n` rises after the 16th falling edge of `sclk`, `sdat_oe` goes low at the third rising `clk` edge, counted as in R2.
- R7: If `conv_n` rises during the busy phase, or during a read with fewer than 16 falling `sclk` edges, the cycle is aborted. `sdat_oe` goes low at the sixth rising `clk` edge, counted as in R2, which is three cycles later than in R6.
- R8: A low `chan_sel` at the start of the cycle selects `res_a`, and a high level selects `res_b`. Changing `chan_sel` later in the cycle has no effect on the word that is shifted out.
- R9: The selected result is latched when the ready marker is raised. Later changes on `res_a` or `res_b` have no effect on the word that is shifted out.
- R10: Edges on `sclk` outside the read phase are ignored and do not use up bits of the word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| conv_n | input | 1 | Active-low convert start from the host, asynchronous to `clk` |
| chan_sel | input | 1 | Channel select: 0 selects `res_a`, 1 selects `res_b` |
| sclk | input | 1 | Serial read clock from the host, asynchronous to `clk` |
| lat_cfg | input | LAT_W | Busy-to-ready latency in clock cycles minus one |
| res_a | input | RES_W | Parallel result for the first channel |
| res_b | input | RES_W | Parallel result for the second channel |
| sdat_o | output | 1 | Serial data value |
| sdat_oe | output | 1 | Serial data drive enable; when low, the pin is high impedance |

## Verification
A host-side input takes effect at the third rising `clk` edge after it first appears: two edges for the synchronizer and one for the control register. The ready marker follows `sdat_oe` by `lat_cfg`+1 edges, and an abort adds three more edges before release. The bench drives inputs just after a falling `clk` edge and records the cycle count at that moment. A behavioural model keeps the last three samples of each host input and predicts `sdat_oe` and `sdat_o`; the bench compares them with the outputs at every falling edge. Further checks compare the measured edge counts for start, ready and release with those offsets. They also compare each word the host captures on rising `sclk` edges with the marker bit followed by the latched result.

// File: rtl/rdo_pkg.sv
package rdo_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_BUSY  = 3'd1,
    ST_READ  = 3'd2,
    ST_HOLD  = 3'd3,
    ST_ABORT = 3'd4
  } rdo_state_e;

endpackage

// File: rtl/rdo_rst_sync.sv
module rdo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] chain_q;

  // assert asynchronously, release after STAGES clock edges
  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_out = chain_q[STAGES-1];

endmodule

// File: rtl/rdo_edge_sync.sv
module rdo_edge_sync #(
  parameter int               WIDTH   = 2,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] last_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= {STAGES{RST_VAL[g]}};
        last_q <= RST_VAL[g];
      end else begin
        sync_q <= {sync_q[STAGES-2:0], async_i[g]};
        last_q <= sync_q[STAGES-1];
      end
    end

    assign level_o[g] = sync_q[STAGES-1];
    assign last_o[g]  = last_q;
  end

endmodule

// File: rtl/rdo_shift.sv
module rdo_shift #(
  parameter  int WIDTH = 16,
  localparam int CW    = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic             shift_i,
  output logic             msb_o,
  output logic [CW-1:0]    shifts_o
);

  logic [WIDTH-1:0] word_q, word_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             upd_en;

  always_comb begin
    upd_en = load_i | shift_i;
    word_d = word_q;
    cnt_d  = cnt_q;
    if (load_i) begin
      word_d = load_val_i;
      cnt_d  = '0;
    end else if (shift_i) begin
      word_d = {word_q[WIDTH-2:0], 1'b0};
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else if (upd_en) begin
      word_q <= word_d;
      cnt_q  <= cnt_d;
    end
  end

  assign msb_o    = word_q[WIDTH-1];
  assign shifts_o = cnt_q;

endmodule

// File: rtl/serial_readout_port.sv
module serial_readout_port #(
  parameter int RES_W       = 15,
  parameter int LAT_W       = 8,
  parameter int ABORT_CYC   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_n,
  input  logic             chan_sel,
  input  logic             sclk,
  input  logic [LAT_W-1:0] lat_cfg,
  input  logic [RES_W-1:0] res_a,
  input  logic [RES_W-1:0] res_b,
  output logic             sdat_o,
  output logic             sdat_oe
);
  import rdo_pkg::*;

  localparam int WORD_W = RES_W + 1;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam int ACNT_W = $clog2(ABORT_CYC + 1);

  logic             rst_n_s;
  logic [1:0]       lvl, last;
  logic             conv_fall, conv_rise, sclk_fall;
  rdo_state_e       state_q, state_d;
  logic [LAT_W-1:0] lat_q, lat_d;
  logic             lat_en;
  logic             chan_q, chan_en;
  logic [ACNT_W-1:0] acnt_q, acnt_d;
  logic             acnt_en;
  logic             load, shift, msb;
  logic [CNT_W-1:0] shifts;
  logic [WORD_W-1:0] load_val;

  rdo_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  // bit 0: convert start (idle high), bit 1: serial clock (idle low)
  rdo_edge_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .async_i ({sclk, conv_n}),
    .level_o (lvl),
    .last_o  (last)
  );

  assign conv_fall = ~lvl[0] &  last[0];
  assign conv_rise =  lvl[0] & ~last[0];
  assign sclk_fall = ~lvl[1] &  last[1];

  assign load_val = {1'b1, (chan_q ? res_b : res_a)};

  rdo_shift #(.WIDTH(WORD_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .load_i     (load),
    .load_val_i (load_val),
    .shift_i    (shift),
    .msb_o      (msb),
    .shifts_o   (shifts)
  );

  always_comb begin
    state_d = state_q;
    lat_d   = lat_q;
    lat_en  = 1'b0;
    chan_en = 1'b0;
    acnt_d  = acnt_q;
    acnt_en = 1'b0;
    load    = 1'b0;
    shift   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (conv_fall) begin
          state_d = ST_BUSY;
          lat_d   = lat_cfg;
          lat_en  = 1'b1;
          chan_en = 1'b1;
        end
      end
      ST_BUSY: begin
        if (conv_rise) begin
          state_d = ST_ABORT;
          acnt_d  = '0;
          acnt_en = 1'b1;
        end else if (lat_q == '0) begin
          state_d = ST_READ;
          load    = 1'b1;
        end else begin
          lat_d  = lat_q - 1'b1;
          lat_en = 1'b1;
        end
      end
      ST_READ: begin
        if (conv_rise) begin
          state_d = ST_ABORT;
          acnt_d  = '0;
          acnt_en = 1'b1;
        end else if (sclk_fall) begin
          shift = 1'b1;
          if (shifts == CNT_W'(WORD_W - 1)) begin
            state_d = ST_HOLD;
          end
        end
      end
      ST_HOLD: begin
        if (conv_rise) begin
          state_d = ST_IDLE;
        end
      end
      ST_ABORT: begin
        if (acnt_q == ACNT_W'(ABORT_CYC - 1)) begin
          state_d = ST_IDLE;
        end else begin
          acnt_d  = acnt_q + 1'b1;
          acnt_en = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      lat_q   <= '0;
      chan_q  <= 1'b0;
      acnt_q  <= '0;
    end else begin
      state_q <= state_d;
      if (lat_en)  lat_q  <= lat_d;
      if (chan_en) chan_q <= chan_sel;
      if (acnt_en) acnt_q <= acnt_d;
    end
  end

  assign sdat_oe = (state_q != ST_IDLE);
  assign sdat_o  = ((state_q == ST_READ) || (state_q == ST_HOLD)) & msb;

endmodule

// File: rtl/rdo_checker.sv
module rdo_checker
  import rdo_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input rdo_state_e state,
  input logic       conv_fall,
  input logic       conv_rise,
  input logic       sclk_fall,
  input logic       load,
  input logic       sdat_o,
  input logic       sdat_oe
);

  assert_start_from_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdat_oe) |-> $past(conv_fall));

  assert_busy_drives_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUSY) |-> (sdat_oe && !sdat_o));

  assert_ready_marker_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> sdat_o);

  assert_shift_on_fall_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_READ) && ($past(state) == ST_READ) && !$past(sclk_fall)) |-> $stable(sdat_o));

  assert_release_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_HOLD) && conv_rise) |=> !sdat_oe);

  assert_abort_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (((state == ST_READ) || (state == ST_BUSY)) && conv_rise) |=> (state == ST_ABORT));

  assert_abort_driven_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ABORT) |-> sdat_oe);

endmodule

bind serial_readout_port rdo_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .state     (state_q),
  .conv_fall (conv_fall),
  .conv_rise (conv_rise),
  .sclk_fall (sclk_fall),
  .load      (load),
  .sdat_o    (sdat_o),
  .sdat_oe   (sdat_oe)
);

// File: tb/sim_serial_readout_port.sv
module sim_serial_readout_port;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        conv_n;
  logic        chan_sel;
  logic        sclk;
  logic [7:0]  lat_cfg;
  logic [14:0] res_a;
  logic [14:0] res_b;
  logic        sdat_o;
  logic        sdat_oe;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;
  int t_oe;

  always #2 clk = ~clk;

  serial_readout_port u0 (
    .clk(clk), .rst_n(rst_n), .conv_n(conv_n), .chan_sel(chan_sel), .sclk(sclk),
    .lat_cfg(lat_cfg), .res_a(res_a), .res_b(res_b), .sdat_o(sdat_o), .sdat_oe(sdat_oe)
  );

  always @(posedge clk) cyc++;

  // behavioural reference: 0 idle, 1 busy, 2 read, 3 hold, 4 abort
  int          ms, mlat, mch, macnt, mbits;
  logic [15:0] mword;
  logic        c1, c2, c3, s1, s2, s3;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms = 0; mlat = 0; mch = 0; macnt = 0; mbits = 0; mword = '0;
      c1 = 1; c2 = 1; c3 = 1; s1 = 0; s2 = 0; s3 = 0;
    end else begin
      logic cf, cr, sf;
      cf = c3 && !c2;
      cr = !c3 && c2;
      sf = s3 && !s2;
      case (ms)
        0: if (cf) begin ms = 1; mlat = int'(lat_cfg); mch = int'(chan_sel); end
        1: if (cr) begin ms = 4; macnt = 0; end
           else if (mlat == 0) begin ms = 2; mbits = 0; mword = {1'b1, (mch != 0) ? res_b : res_a}; end
           else mlat--;
        2: if (cr) begin ms = 4; macnt = 0; end
           else if (sf) begin mword = mword << 1; if (mbits == 15) ms = 3; mbits++; end
        3: if (cr) ms = 0;
        4: if (macnt == 2) ms = 0; else macnt++;
        default: ms = 0;
      endcase
      c3 = c2; c2 = c1; c1 = conv_n;
      s3 = s2; s2 = s1; s1 = sclk;
    end
  end

  function automatic string st_tag(int s);
    case (s)
      1: return "R2";
      2: return "R4";
      3: return "R6";
      4: return "R7";
      default: return "R1";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    logic eoe, esd;
    eoe = (ms != 0);
    esd = ((ms == 2) || (ms == 3)) ? mword[15] : 1'b0;
    check(st_tag(ms), {31'd0, sdat_oe}, {31'd0, eoe}, "sdat_oe per cycle");
    if (eoe) check(st_tag(ms), {31'd0, sdat_o}, {31'd0, esd}, "sdat_o per cycle");
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_conv(logic ch, logic [7:0] lat);
    @(negedge clk);
    chan_sel = ch;
    lat_cfg  = lat;
    conv_n   = 1'b0;
  endtask

  task automatic wait_oe(int c0);
    int k = 0;
    while (!sdat_oe && k < 50) begin @(negedge clk); k++; end
    t_oe = cyc;
    check("R2", cyc - c0, 3, "cycles from start to drive enable");
    check("R2", {31'd0, sdat_o}, 0, "busy level");
  endtask

  task automatic wait_ready(int lat, bit timed);
    int k = 0;
    while (!sdat_o && k < 400) begin @(negedge clk); k++; end
    if (timed) check("R3", cyc - t_oe, lat + 1, "cycles from drive enable to ready");
  endtask

  task automatic pulse_sclk(int n);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1; idle(4);
      sclk = 1'b0; idle(4);
    end
  endtask

  task automatic read_word(int n, output logic [15:0] w);
    w = '0;
    for (int i = 0; i < n; i++) begin
      w = {w[14:0], sdat_o};
      sclk = 1'b1; idle(4);
      sclk = 1'b0; idle(4);
    end
  endtask

  task automatic end_conv(int exp_delay, string tag);
    int c0, k;
    @(negedge clk);
    conv_n = 1'b1;
    c0 = cyc;
    k = 0;
    while (sdat_oe && k < 50) begin @(negedge clk); k++; end
    check(tag, cyc - c0, exp_delay, "cycles from start release to high impedance");
    idle(6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    rst_n = 1'b0; conv_n = 1'b1; chan_sel = 1'b0; sclk = 1'b0;
    lat_cfg = 8'd0; res_a = 15'h5A3C; res_b = 15'h1234;
    idle(3);
    check("R1", {31'd0, sdat_oe}, 0, "drive enable during reset");
    rst_n = 1'b1;
    idle(6);
    check("R1", {31'd0, sdat_oe}, 0, "drive enable idle after reset");

    // channel 1, latency 4, full read
    start_conv(1'b0, 8'd4);
    wait_oe(cyc);
    wait_ready(4, 1);
    read_word(16, w);
    check("R5", {16'd0, w}, {16'd0, 1'b1, 15'h5A3C}, "word read from first channel");
    check("R8", {31'd0, w[15]}, 1, "marker ahead of first channel result");
    end_conv(3, "R6");

    // channel 2, latency 0, select and result change mid-cycle
    start_conv(1'b1, 8'd0);
    wait_oe(cyc);
    chan_sel = 1'b0;
    wait_ready(0, 1);
    res_b = 15'h0F0F;
    read_word(16, w);
    check("R8", {16'd0, w}, {16'd0, 1'b1, 15'h1234}, "second channel kept after select change");
    check("R9", {16'd0, w}, {16'd0, 1'b1, 15'h1234}, "result latched at ready");
    end_conv(3, "R6");

    // serial clock activity during busy is ignored
    res_a = 15'h7FFF;
    start_conv(1'b0, 8'd20);
    pulse_sclk(2);
    wait_ready(20, 0);
    read_word(16, w);
    check("R10", {16'd0, w}, {16'd0, 1'b1, 15'h7FFF}, "word intact after early clock pulses");
    end_conv(3, "R6");

    // abort during read
    res_b = 15'h0001;
    start_conv(1'b1, 8'd2);
    wait_oe(cyc);
    wait_ready(2, 1);
    read_word(5, w);
    check("R4", {16'd0, w}, {27'd0, 5'b10000}, "first five bits of short read");
    end_conv(6, "R7");

    // abort during busy
    start_conv(1'b0, 8'd30);
    wait_oe(cyc);
    end_conv(6, "R7");

    // asynchronous reset during a read
    res_a = 15'h2AAA;
    start_conv(1'b0, 8'd1);
    wait_oe(cyc);
    wait_ready(1, 1);
    read_word(3, w);
    #1 rst_n = 1'b0;
    #0.5 check("R1", {31'd0, sdat_oe}, 0, "drive enable right after reset assertion");
    conv_n = 1'b1;
    idle(3);
    rst_n = 1'b1;
    idle(6);

    // normal read after reset
    start_conv(1'b0, 8'd3);
    wait_oe(cyc);
    wait_ready(3, 1);
    read_word(16, w);
    check("R5", {16'd0, w}, {16'd0, 1'b1, 15'h2AAA}, "word after reset recovery");
    end_conv(3, "R6");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule